// File: doc/BRIEF.md
# Dynamic Power Mode Sequencer

This controller keeps track of which of five operating modes a processor is in: full-on, active, sleep, deep sleep and hibernate. From that mode it drives the gating enables for the core clock and the system clock. It also drives the PLL bypass-path select, the internal supply regulator enable, the three-state control of the external pads, and a flag that says whether DMA into L1 memory is allowed. Clocks appear only as enables. The analog PLL, the regulator circuit and the clock generation are outside this block.

Software moves the controller between the awake modes with one-cycle mode requests. It enters hibernate by writing the regulator frequency field as zero. The block checks every request against the current mode and the PLL enable bit. A request that is not legal leaves the mode unchanged and sets a sticky error flag, which software clears. Each low-power mode has its own exit path. Sleep ends on a wakeup event, and the BYPASS bit decides whether the exit goes to active or to full-on. Deep sleep and hibernate end only on the RTC interrupt, which leads to active, or on a reset request, which leads to full-on. Both the RTC interrupt and the reset request are asynchronous, so each passes through a two-flop synchroniser before it takes effect.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on reset (rst_n low at a clock edge), cur_mode is 0 (full-on), cclk_en, sclk_en and vreg_en are 1, pad_hiz and pll_bypass_en are 0, and req_err is 0.
- R2: Mode codes are 0 full-on, 1 active, 2 sleep, 3 deep sleep, 4 hibernate. The outputs {cclk_en, sclk_en, pll_bypass_en, vreg_en, pad_hiz, dma_l1_ok} depend only on cur_mode: 110101 for full-on, 111101 for active, 010100 for sleep, 000100 for deep sleep, 000010 for hibernate.
- R3: When the mode is full-on or active and req_valid is high for one cycle, the following requests take effect at the next edge: active (code 1) from full-on; full-on (code 0) from active; sleep (code 2) from either mode; deep sleep (code 3) from either mode.
- R4: A request for full-on or for sleep while pll_en is 0 is refused. The mode does not change and req_err is set.
- R5: In sleep, a wakeup event (wake_evt high at an edge) moves the mode to active if bypass is 1 and to full-on if bypass is 0. Without a wakeup event the controller stays in sleep.
- R6: In deep sleep, wake_evt and mode requests have no effect on the mode. A synchronised RTC interrupt moves the mode to active, and a synchronised reset request moves it to full-on.
- R7: A write (vr_wr high) with vr_freq equal to 00 moves the mode from full-on or active to hibernate at the next edge. A write with any other value changes neither the mode nor req_err. A write of 00 in sleep, deep sleep or hibernate is refused and sets req_err.
- R8: In hibernate, only a synchronised RTC interrupt (which leads to active) or a synchronised reset request (which leads to full-on) changes the mode. wake_evt and mode requests do not.
- R9: rtc_irq_async and reset_req_async act through a two-flop synchroniser. When one is raised before edge k, the mode is unchanged after edges k and k+1 and changes at edge k+2.
- R10: Any request that is not legal (a code of 4 to 7, a request made outside full-on or active, a request for the current mode, full-on requested from full-on, active requested from active) leaves the mode unchanged and sets req_err. req_err stays at 1 until err_clr is high at an edge with no new error in that same cycle. When both happen in the same cycle, the new error wins.
- R11: A synchronised reset request moves the mode to full-on from any mode and takes priority over any request in the same cycle.
- R12: dma_l1_ok is 1 in full-on and active and 0 in sleep, deep sleep and hibernate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| pll_en | input | 1 | PLL enable bit from the control register |
| bypass | input | 1 | BYPASS bit; selects the sleep exit target |
| vr_wr | input | 1 | Write strobe for the regulator frequency field |
| vr_freq | input | VR_W (2) | Regulator frequency field value; 00 enters hibernate |
| wake_evt | input | 1 | Synchronous wakeup event |
| rtc_irq_async | input | 1 | Asynchronous RTC interrupt |
| reset_req_async | input | 1 | Asynchronous reset request |
| err_clr | input | 1 | Clears the sticky request error |
| cur_mode | output | 3 | Current mode code |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_bypass_en | output | 1 | PLL bypass path select |
| vreg_en | output | 1 | Internal supply regulator enable |
| pad_hiz | output | 1 | External pads three-state |
| dma_l1_ok | output | 1 | DMA into L1 memory allowed |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
The mode register is the only state that sets the outputs, so a wrong transition shows up on cur_mode and on the whole enable pattern at the edge where the transition happens. The exception is an RTC or reset event, which shows up two edges later. An exit from sleep that goes to the wrong target leaves pll_bypass_en inverted. A transition that should have been refused shows as a mode change with req_err still at 0 one cycle after the request. A synchroniser with the wrong number of stages moves the wake edge one cycle early or one cycle late.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power mode sequencer.
// Assumes the mode codes below are visible to software and stay fixed.
package pwr_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_FULL   = 3'd0,
        PM_ACTIVE = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_DEEP   = 3'd3,
        PM_HIBER  = 3'd4
    } pm_mode_e;

    typedef struct packed {
        logic cclk_en;
        logic sclk_en;
        logic byp_en;
        logic vreg_en;
        logic pad_hiz;
        logic dma_ok;
    } pm_ctl_t;

endpackage

// File: rtl/pm_sync.sv
// Multi-stage flop synchroniser, one independent chain per bit.
// Assumes STAGES >= 2. Each chain clears to zero under synchronous reset.
module pm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/pm_req_check.sv
// Checks software requests against the current mode and the PLL enable bit.
// Produces a go/target pair for a legal request and a bad flag for one that
// is refused. A write of the zero regulator code wins over a same-cycle request.
module pm_req_check
    import pwr_mode_pkg::*;
#(
    parameter int VR_W = 2
) (
    input  pm_mode_e               cur_mode,
    input  logic                   req_valid,
    input  logic [MODE_W-1:0]      req_mode,
    input  logic                   pll_en,
    input  logic                   vr_wr,
    input  logic [VR_W-1:0]        vr_freq,
    output logic                   sw_go,
    output pm_mode_e               sw_target,
    output logic                   sw_bad
);
    localparam logic [VR_W-1:0] VR_OFF = '0;

    logic awake;
    logic hib_wr;
    logic legal;

    assign awake  = (cur_mode == PM_FULL) || (cur_mode == PM_ACTIVE);
    assign hib_wr = vr_wr && (vr_freq == VR_OFF);

    // Decide whether the requested code is a legal target from the current mode.
    always_comb begin
        legal = 1'b0;
        unique case (req_mode)
            3'd0:    legal = (cur_mode == PM_ACTIVE) && pll_en;
            3'd1:    legal = (cur_mode == PM_FULL);
            3'd2:    legal = pll_en;
            3'd3:    legal = 1'b1;
            default: legal = 1'b0;
        endcase
        legal = legal && awake;
    end

    // Pick between a hibernate write and a mode request, and flag refusals.
    always_comb begin
        sw_go     = 1'b0;
        sw_target = cur_mode;
        sw_bad    = 1'b0;
        if (hib_wr) begin
            sw_go     = awake;
            sw_target = PM_HIBER;
            sw_bad    = !awake || req_valid;
        end else if (req_valid) begin
            sw_go     = legal;
            sw_target = pm_mode_e'(req_mode);
            sw_bad    = !legal;
        end
    end
endmodule

// File: rtl/pm_mode_fsm.sv
// Holds the current mode and the sticky error flag.
// Priority: synchronised reset request, then the exit rule of the current
// mode, then a legal software request (taken only in full-on or active).
module pm_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rst_s,
    input  logic     rtc_s,
    input  logic     wake_evt,
    input  logic     bypass,
    input  logic     sw_go,
    input  pm_mode_e sw_target,
    input  logic     sw_bad,
    input  logic     err_clr,
    output pm_mode_e mode_o,
    output logic     err_o
);
    pm_mode_e mode_q, mode_d;
    logic     err_q;

    // Work out the next mode from the wake sources and software.
    always_comb begin
        mode_d = mode_q;
        if (rst_s) begin
            mode_d = PM_FULL;
        end else begin
            unique case (mode_q)
                PM_SLEEP: if (wake_evt) mode_d = bypass ? PM_ACTIVE : PM_FULL;
                PM_DEEP,
                PM_HIBER: if (rtc_s) mode_d = PM_ACTIVE;
                default:  if (sw_go) mode_d = sw_target;
            endcase
        end
    end

    // Register the mode and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_FULL;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            err_q  <= sw_bad || (err_q && !err_clr);
        end
    end

    assign mode_o = mode_q;
    assign err_o  = err_q;

    // R11: a synchronised reset request always lands in full-on.
    p_rst_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_s |=> mode_q == PM_FULL);

    // R5: the BYPASS bit picks the sleep exit target.
    p_sleep_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_SLEEP && !rst_s && wake_evt) |=>
        mode_q == ($past(bypass) ? PM_ACTIVE : PM_FULL));

    // R6: deep sleep holds until the RTC interrupt or a reset request.
    p_deep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_DEEP && !rst_s && !rtc_s) |=> mode_q == PM_DEEP);

    // R6: the RTC interrupt takes deep sleep to active.
    p_deep_rtc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_DEEP && !rst_s && rtc_s) |=> mode_q == PM_ACTIVE);

    // R8: hibernate holds until the RTC interrupt or a reset request.
    p_hib_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_HIBER && !rst_s && !rtc_s) |=> mode_q == PM_HIBER);

    // R10: the error flag is sticky until cleared.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/pm_out_decode.sv
// Turns the current mode into the gating, regulator, pad and DMA controls.
// Pure decode. Assumes the mode is already registered, so the outputs are glitch-free.
module pm_out_decode
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e mode_i,
    output pm_ctl_t  ctl_o
);
    // Map each mode to its control pattern.
    always_comb begin
        ctl_o = '0;
        unique case (mode_i)
            PM_FULL:   ctl_o = '{cclk_en:1'b1, sclk_en:1'b1, byp_en:1'b0,
                                 vreg_en:1'b1, pad_hiz:1'b0, dma_ok:1'b1};
            PM_ACTIVE: ctl_o = '{cclk_en:1'b1, sclk_en:1'b1, byp_en:1'b1,
                                 vreg_en:1'b1, pad_hiz:1'b0, dma_ok:1'b1};
            PM_SLEEP:  ctl_o = '{cclk_en:1'b0, sclk_en:1'b1, byp_en:1'b0,
                                 vreg_en:1'b1, pad_hiz:1'b0, dma_ok:1'b0};
            PM_DEEP:   ctl_o = '{cclk_en:1'b0, sclk_en:1'b0, byp_en:1'b0,
                                 vreg_en:1'b1, pad_hiz:1'b0, dma_ok:1'b0};
            default:   ctl_o = '{cclk_en:1'b0, sclk_en:1'b0, byp_en:1'b0,
                                 vreg_en:1'b0, pad_hiz:1'b1, dma_ok:1'b0};
        endcase
    end

    // R2: the core clock never runs without the system clock.
    p_clk_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.cclk_en |-> ctl_o.sclk_en);

    // R12: DMA is allowed only while the core clock runs.
    p_dma_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.dma_ok |-> ctl_o.cclk_en);

    // R7: three-stated pads only with the supply and clocks off.
    p_hiz_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.pad_hiz |-> (!ctl_o.vreg_en && !ctl_o.sclk_en));
endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode sequencer: synchroniser, request checker,
// mode register and output decode. Assumes all synchronous inputs are
// already in the clk domain. Only the RTC and reset request are asynchronous.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VR_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              pll_en,
    input  logic              bypass,
    input  logic              vr_wr,
    input  logic [VR_W-1:0]   vr_freq,
    input  logic              wake_evt,
    input  logic              rtc_irq_async,
    input  logic              reset_req_async,
    input  logic              err_clr,
    output logic [MODE_W-1:0] cur_mode,
    output logic              cclk_en,
    output logic              sclk_en,
    output logic              pll_bypass_en,
    output logic              vreg_en,
    output logic              pad_hiz,
    output logic              dma_l1_ok,
    output logic              req_err
);
    logic [1:0] async_raw, async_sync;
    logic       rst_s, rtc_s;
    logic       sw_go, sw_bad;
    pm_mode_e   sw_target, mode;
    pm_ctl_t    ctl;

    assign async_raw = {reset_req_async, rtc_irq_async};
    assign rst_s     = async_sync[1];
    assign rtc_s     = async_sync[0];

    pm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_raw),
        .sync_o  (async_sync)
    );

    pm_req_check #(.VR_W(VR_W)) u_check (
        .cur_mode  (mode),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .pll_en    (pll_en),
        .vr_wr     (vr_wr),
        .vr_freq   (vr_freq),
        .sw_go     (sw_go),
        .sw_target (sw_target),
        .sw_bad    (sw_bad)
    );

    pm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_s     (rst_s),
        .rtc_s     (rtc_s),
        .wake_evt  (wake_evt),
        .bypass    (bypass),
        .sw_go     (sw_go),
        .sw_target (sw_target),
        .sw_bad    (sw_bad),
        .err_clr   (err_clr),
        .mode_o    (mode),
        .err_o     (req_err)
    );

    pm_out_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .mode_i(mode),
        .ctl_o (ctl)
    );

    assign cur_mode      = mode;
    assign cclk_en       = ctl.cclk_en;
    assign sclk_en       = ctl.sclk_en;
    assign pll_bypass_en = ctl.byp_en;
    assign vreg_en       = ctl.vreg_en;
    assign pad_hiz       = ctl.pad_hiz;
    assign dma_l1_ok     = ctl.dma_ok;

    // R4: with the PLL off, full-on or sleep requests are refused and flagged.
    p_pll_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pll_en && !vr_wr && !rst_s &&
         (mode == PM_FULL || mode == PM_ACTIVE) &&
         (req_mode == 3'd0 || req_mode == 3'd2))
        |=> ($stable(cur_mode) && req_err));
endmodule

// File: tb/pwr_mode_seq_tb_top.sv
// Sweeps every mode, request code and PLL setting, then the wake paths.
module pwr_mode_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, req_valid, pll_en, bypass, vr_wr, wake_evt;
    logic       rtc_irq_async, reset_req_async, err_clr;
    logic [2:0] req_mode;
    logic [1:0] vr_freq;
    logic [2:0] cur_mode;
    logic       cclk_en, sclk_en, pll_bypass_en, vreg_en, pad_hiz, dma_l1_ok, req_err;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .pll_en(pll_en), .bypass(bypass), .vr_wr(vr_wr), .vr_freq(vr_freq),
        .wake_evt(wake_evt), .rtc_irq_async(rtc_irq_async),
        .reset_req_async(reset_req_async), .err_clr(err_clr),
        .cur_mode(cur_mode), .cclk_en(cclk_en), .sclk_en(sclk_en),
        .pll_bypass_en(pll_bypass_en), .vreg_en(vreg_en), .pad_hiz(pad_hiz),
        .dma_l1_ok(dma_l1_ok), .req_err(req_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected output pattern {cclk,sclk,byp,vreg,hiz,dma} per mode (R2, R12).
    function automatic int outs_of(input int m);
        case (m)
            0:       return 'b110101;
            1:       return 'b111101;
            2:       return 'b010100;
            3:       return 'b000100;
            default: return 'b000010;
        endcase
    endfunction

    function automatic int outs_now();
        return int'({cclk_en, sclk_en, pll_bypass_en, vreg_en, pad_hiz, dma_l1_ok});
    endfunction

    task automatic async_pulse(input bit is_rtc);
        if (is_rtc) rtc_irq_async = 1'b1; else reset_req_async = 1'b1;
        step();
        rtc_irq_async = 1'b0; reset_req_async = 1'b0;
        step();
        step();
    endtask

    task automatic request(input int code);
        req_valid = 1'b1; req_mode = 3'(code);
        step();
        req_valid = 1'b0;
    endtask

    task automatic goto_mode(input int m);
        pll_en = 1'b1;
        async_pulse(1'b0);
        case (m)
            1: request(1);
            2: request(2);
            3: request(3);
            4: begin vr_wr = 1'b1; vr_freq = 2'b00; step(); vr_wr = 1'b0; vr_freq = 2'b11; end
            default: ;
        endcase
        err_clr = 1'b1; step(); err_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; pll_en = 1'b1; bypass = 1'b0;
        vr_wr = 1'b0; vr_freq = 2'b11; wake_evt = 1'b0; rtc_irq_async = 1'b0;
        reset_req_async = 1'b0; err_clr = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 mode", int'(cur_mode), 0);
        chk("R1 outs", outs_now(), outs_of(0));
        chk("R1 err", int'(req_err), 0);

        // R3 R4 R10: sweep start mode x PLL bit x request code.
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 8; c++) begin
                    int  nm;
                    bit  ok;
                    goto_mode(s);
                    chk("R2 outs per mode", outs_now(), outs_of(s));
                    pll_en = p[0];
                    ok = 1'b0;
                    if (s == 0 || s == 1) begin
                        case (c)
                            0: ok = (s == 1) && p == 1;
                            1: ok = (s == 0);
                            2: ok = (p == 1);
                            3: ok = 1'b1;
                            default: ok = 1'b0;
                        endcase
                    end
                    nm = ok ? c : s;
                    request(c);
                    chk($sformatf("R3/R4 mode s=%0d p=%0d c=%0d", s, p, c), int'(cur_mode), nm);
                    chk($sformatf("R10 err s=%0d p=%0d c=%0d", s, p, c), int'(req_err), ok ? 0 : 1);
                    chk("R12 outs after request", outs_now(), outs_of(nm));
                end
            end
        end

        // R5: sleep exit target chosen by BYPASS.
        for (int b = 0; b < 2; b++) begin
            goto_mode(2);
            step();
            chk("R5 sleep holds", int'(cur_mode), 2);
            bypass = b[0]; wake_evt = 1'b1; step(); wake_evt = 1'b0;
            chk("R5 sleep wake target", int'(cur_mode), b == 1 ? 1 : 0);
            chk("R5 bypass output", int'(pll_bypass_en), b);
        end

        // R6 R9: deep sleep ignores wake, RTC reaches active after two sync flops.
        goto_mode(3);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R6 deep ignores wake", int'(cur_mode), 3);
        rtc_irq_async = 1'b1; step(); rtc_irq_async = 1'b0;
        chk("R9 edge k unchanged", int'(cur_mode), 3);
        step();
        chk("R9 edge k+1 unchanged", int'(cur_mode), 3);
        step();
        chk("R6 R9 rtc to active", int'(cur_mode), 1);
        goto_mode(3);
        async_pulse(1'b0);
        chk("R6 reset to full-on", int'(cur_mode), 0);

        // R8: hibernate exit only by RTC or reset.
        goto_mode(4);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R8 hib ignores wake", int'(cur_mode), 4);
        request(0);
        chk("R8 hib ignores request", int'(cur_mode), 4);
        async_pulse(1'b1);
        chk("R8 rtc to active", int'(cur_mode), 1);
        goto_mode(4);
        async_pulse(1'b0);
        chk("R8 reset to full-on", int'(cur_mode), 0);

        // R7: regulator field writes.
        goto_mode(0);
        vr_wr = 1'b1; vr_freq = 2'b01; step(); vr_wr = 1'b0; vr_freq = 2'b11;
        chk("R7 nonzero write mode", int'(cur_mode), 0);
        chk("R7 nonzero write err", int'(req_err), 0);
        goto_mode(1);
        vr_wr = 1'b1; vr_freq = 2'b00; step(); vr_wr = 1'b0; vr_freq = 2'b11;
        chk("R7 active to hib", int'(cur_mode), 4);
        chk("R7 hib outs", outs_now(), outs_of(4));
        goto_mode(2);
        vr_wr = 1'b1; vr_freq = 2'b00; step(); vr_wr = 1'b0; vr_freq = 2'b11;
        chk("R7 sleep write refused", int'(cur_mode), 2);
        chk("R7 sleep write err", int'(req_err), 1);

        // R10: stickiness, set beats clear, clear works.
        step(); step();
        chk("R10 sticky", int'(req_err), 1);
        err_clr = 1'b1; req_valid = 1'b1; req_mode = 3'd6; step();
        err_clr = 1'b0; req_valid = 1'b0;
        chk("R10 set wins", int'(req_err), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        chk("R10 cleared", int'(req_err), 0);

        // R11: reset request beats a same-cycle legal request.
        goto_mode(1);
        reset_req_async = 1'b1; step(); reset_req_async = 1'b0; step();
        request(3);
        chk("R11 reset priority", int'(cur_mode), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule